// File: doc/BRIEF.md
# Ping-Pong Ethernet Receive Buffer with Destination Filter

This block is the receive half of a small memory-mapped Ethernet controller. Frame bytes arrive one per valid cycle, with start and last markers on the first and final byte. Each frame's destination address is compared with the station address held on an input port. A frame is accepted if its first byte has its top bit set (group traffic) or if all six destination bytes match. An accepted frame is packed big-endian into 32-bit words of one of two 2 KB buffers. After each accepted frame the buffer choice alternates when ping-pong operation is enabled. It stays where it is when ping-pong is off.

When a frame completes, the buffer's full flag is set and a one-cycle interrupt pulse may follow. A frame that starts while its target buffer is still full is refused and reported on a one-cycle loss pulse. The CPU reads buffer words and the control words over a word-addressed port. It frees a buffer by writing that buffer's control word with the full flag clear. There is no length register, so software reads the whole buffer.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After reset both full flags, both interrupt-enable flags and the global enable are 0, the target buffer is 0, `rx_ready` is 1 and `irq` and `frame_lost` are 0.
- R2: Byte addresses are `cpu_word*4`. Buffer b data words start at 0x1000 + 0x800*b; the last word of each buffer (0x17FC for buffer 0, 0x1FFC for buffer 1) is its control word, with full flag S in bit 0 and interrupt enable I in bit 3. The global enable is bit 31 of the word at 0x07F8. Every other address reads 0. `rd_data` is valid in the cycle after `cpu_rd` is sampled.
- R3: Frame byte n is stored in word n/4 of the buffer at bits [31-8*(n%4) -: 8]. Byte positions past the end of the frame in its last word read 0.
- R4: A frame is stored only if bit 7 of byte 0 is 1, or if bytes 0..5 equal `station_addr` with byte 0 = `station_addr[47:40]`. Any other frame, and any frame shorter than 6 bytes, causes no data write, no flag change and no interrupt.
- R5: If the target buffer's S is 1 when the start byte is sampled, the frame is not stored, no flag changes, and `frame_lost` is 1 for the one cycle after that edge.
- R6: For an accepted frame, S of its buffer becomes 1 at the clock edge after the one that samples the last byte.
- R7: `irq` is 1 for exactly one cycle, starting at the edge that sets S, if and only if that buffer's I bit and the global enable bit are both 1.
- R8: With `pp_en`=1 the target buffer alternates after each accepted frame. With `pp_en`=0 the target buffer does not change.
- R9: `rx_ready` equals the inverse of buffer 0's S bit.
- R10: A write to a control word loads S from bit 0 and I from bit 3, so writing S=0 frees the buffer. If a frame completes in the same cycle, S ends at 1. Writes to buffer data words have no effect.
- R11: Bytes at positions 2044 and above are not stored, so the control word is never overwritten. A truncated frame still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| station_addr | input | 48 | Station address; bits 47:40 are the first destination byte |
| pp_en | input | 1 | 1 = alternate buffers after each accepted frame |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_ready | output | 1 | Buffer 0 is free |
| frame_lost | output | 1 | One-cycle pulse: frame refused because its buffer was full |
| irq | output | 1 | One-cycle completion interrupt pulse |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_word | input | 11 | Word address (byte address / 4) |
| cpu_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
A read returns data one edge after its strobe is sampled, so the bench samples `rd_data` just after that edge. The final partial word, the full flag and the interrupt pulse all land one edge after the last byte is sampled. Data words that complete mid-frame are written at the edge that samples their fourth byte. The bench therefore waits a few idle cycles after every frame before it reads memory or flags. Interrupt and loss pulses last one cycle; the bench counts them at every falling edge and compares the change in each count over a scenario with the expected change.

// File: rtl/eth_rxpp_pkg.sv
package eth_rxpp_pkg;
    localparam int CTRL_S_BIT = 0;
    localparam int CTRL_I_BIT = 3;
    localparam int GIE_BIT    = 31;
    localparam int MAC_BYTES  = 6;
endpackage

// File: rtl/rxpp_addr_dec.sv
module rxpp_addr_dec #(
    parameter int BUF_BYTES = 2048,
    localparam int WORDS    = BUF_BYTES / 4,
    localparam int WIDX_W   = $clog2(WORDS),
    localparam int WA       = WIDX_W + 2
) (
    input  logic [WA-1:0]     word_i,
    output logic              is_gie_o,
    output logic              is_ctrl_o,
    output logic              is_data_o,
    output logic              buf_o,
    output logic [WIDX_W-1:0] widx_o
);
    logic region;

    always_comb begin
        region    = word_i[WA-1];
        buf_o     = word_i[WA-2];
        widx_o    = word_i[WIDX_W-1:0];
        is_ctrl_o = region && (widx_o == WIDX_W'(WORDS - 1));
        is_data_o = region && !is_ctrl_o;
        is_gie_o  = !region && !buf_o && (widx_o == WIDX_W'(WORDS - 2));
    end
endmodule

// File: rtl/rxpp_dest_filter.sv
module rxpp_dest_filter
    import eth_rxpp_pkg::*;
(
    input  logic [2:0]  pos_i,
    input  logic [7:0]  data_i,
    input  logic [47:0] station_i,
    output logic        hit_o
);
    logic [7:0] lane_eq;

    for (genvar k = 0; k < 8; k++) begin : g_lane
        if (k < MAC_BYTES) begin : g_cmp
            assign lane_eq[k] = (data_i == station_i[47-8*k -: 8]);
        end else begin : g_pad
            assign lane_eq[k] = 1'b0;
        end
    end

    assign hit_o = lane_eq[pos_i];
endmodule

// File: rtl/rxpp_bufmem.sv
module rxpp_bufmem #(
    parameter int WORDS = 1024,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [31:0]   wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [31:0]   rdata_o
);
    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        if (re_i) begin
            rdata_o <= mem_q[raddr_i];
        end
    end
endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong
    import eth_rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    localparam int ADDR_W   = $clog2(BUF_BYTES) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       station_addr,
    input  logic              pp_en,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              rx_ready,
    output logic              frame_lost,
    output logic              irq,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-3:0] cpu_word,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       rd_data
);
    localparam int WORDS     = BUF_BYTES / 4;
    localparam int WIDX_W    = $clog2(WORDS);
    localparam int MAW       = WIDX_W + 1;
    localparam int MAX_BYTES = BUF_BYTES - 4;
    localparam int CNT_W     = $clog2(BUF_BYTES) + 1;

    typedef struct packed {
        logic             act;
        logic             pass;
        logic             hit;
        logic             bcast;
        logic [CNT_W-1:0] cnt;
        logic [23:0]      acc;
        logic [31:0]      w0;
        logic             cur;
        logic             fin;
        logic             pend;
        logic [MAW-1:0]   paddr;
        logic [31:0]      pdata;
        logic             sel;
        logic [1:0]       full;
        logic [1:0]       ien;
        logic             gie;
        logic             irq;
        logic             lost;
        logic             rmem;
        logic [31:0]      rreg;
    } st_t;

    st_t q, d;

    logic              dec_gie, dec_ctrl, dec_data, dec_buf;
    logic [WIDX_W-1:0] dec_widx;
    logic [CNT_W-1:0]  pos;
    logic              filt_hit;
    logic              mem_we;
    logic [MAW-1:0]    mem_waddr;
    logic [31:0]       mem_wdata;
    logic              mem_re;
    logic [31:0]       mem_rdata;
    logic              unused_wdata;

    assign unused_wdata = ^{cpu_wdata[30:4], cpu_wdata[2:1]};

    rxpp_addr_dec #(.BUF_BYTES(BUF_BYTES)) dec_i (
        .word_i    (cpu_word),
        .is_gie_o  (dec_gie),
        .is_ctrl_o (dec_ctrl),
        .is_data_o (dec_data),
        .buf_o     (dec_buf),
        .widx_o    (dec_widx)
    );

    assign pos = rx_sof ? '0 : q.cnt;

    rxpp_dest_filter filt_i (
        .pos_i     (pos[2:0]),
        .data_i    (rx_data),
        .station_i (station_addr),
        .hit_o     (filt_hit)
    );

    assign mem_re = cpu_rd && dec_data;

    rxpp_bufmem #(.WORDS(2 * WORDS)) mem_i (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .re_i    (mem_re),
        .raddr_i ({dec_buf, dec_widx}),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        logic [31:0]       word;
        logic [31:0]       part;
        logic [WIDX_W-1:0] pidx;

        d         = q;
        d.irq     = 1'b0;
        d.lost    = 1'b0;
        d.fin     = 1'b0;
        d.pend    = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = '0;

        word = {q.acc, rx_data};
        pidx = pos[WIDX_W+1:2];
        case (pos[1:0])
            2'd0:    part = {word[7:0], 24'h0};
            2'd1:    part = {word[15:0], 16'h0};
            2'd2:    part = {word[23:0], 8'h0};
            default: part = word;
        endcase

        // software access to control and enable words
        if (cpu_wr) begin
            if (dec_gie) begin
                d.gie = cpu_wdata[GIE_BIT];
            end
            if (dec_ctrl) begin
                d.full[dec_buf] = cpu_wdata[CTRL_S_BIT];
                d.ien[dec_buf]  = cpu_wdata[CTRL_I_BIT];
            end
        end

        // trailing partial word of the previous frame
        if (q.pend) begin
            mem_we    = 1'b1;
            mem_waddr = q.paddr;
            mem_wdata = q.pdata;
        end

        // completion stage: hardware set of S wins over a software clear
        if (q.fin) begin
            d.full[q.cur] = 1'b1;
            d.irq         = q.ien[q.cur] && q.gie;
            if (pp_en) begin
                d.sel = ~q.sel;
            end
        end

        // incoming byte
        if (rx_valid) begin
            if (rx_sof) begin
                d.cur   = d.sel;
                d.pass  = 1'b0;
                d.hit   = 1'b1;
                d.bcast = rx_data[7];
                if (d.full[d.sel]) begin
                    d.act  = 1'b0;
                    d.lost = 1'b1;
                end else begin
                    d.act = 1'b1;
                end
            end
            d.cnt = (pos == {CNT_W{1'b1}}) ? pos : pos + CNT_W'(1);
            d.acc = {q.acc[15:0], rx_data};
            if (d.act) begin
                if (pos < CNT_W'(MAC_BYTES)) begin
                    d.hit = d.hit && filt_hit;
                end
                if (pos == CNT_W'(3)) begin
                    d.w0 = word;
                end
                if (pos == CNT_W'(MAC_BYTES - 1)) begin
                    if (d.bcast || d.hit) begin
                        d.pass    = 1'b1;
                        mem_we    = 1'b1;
                        mem_waddr = {d.cur, WIDX_W'(0)};
                        mem_wdata = q.w0;
                    end else begin
                        d.act = 1'b0;
                    end
                end else if (d.pass && pos[1:0] == 2'd3 && pos < CNT_W'(MAX_BYTES)) begin
                    mem_we    = 1'b1;
                    mem_waddr = {d.cur, pidx};
                    mem_wdata = word;
                end
                if (rx_eof) begin
                    if (d.pass) begin
                        d.fin = 1'b1;
                        if (pos[1:0] != 2'd3 && pos < CNT_W'(MAX_BYTES)) begin
                            d.pend  = 1'b1;
                            d.paddr = {d.cur, pidx};
                            d.pdata = part;
                        end
                    end
                    d.act = 1'b0;
                end
            end
        end

        // read capture
        if (cpu_rd) begin
            d.rmem = dec_data;
            d.rreg = '0;
            if (dec_ctrl) begin
                d.rreg[CTRL_S_BIT] = q.full[dec_buf];
                d.rreg[CTRL_I_BIT] = q.ien[dec_buf];
            end
            if (dec_gie) begin
                d.rreg[GIE_BIT] = q.gie;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rx_ready   = ~q.full[0];
    assign frame_lost = q.lost;
    assign irq        = q.irq;
    assign rd_data    = q.rmem ? mem_rdata : q.rreg;

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        q.irq |-> $past(q.gie)); // R7

    AST_LOST_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        q.lost |-> $past(rx_valid && rx_sof)); // R5

    AST_CTRL_WORD_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_waddr[WIDX_W-1:0] != WIDX_W'(WORDS - 1))); // R11

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pp_en) |-> $stable(q.sel)); // R8

    for (genvar b = 0; b < 2; b++) begin : g_full_chk
        AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.full[b]) |->
                ($past(q.fin) && ($past(q.cur) == 1'(b))) ||
                $past(cpu_wr && dec_ctrl && (dec_buf == 1'(b)) && cpu_wdata[CTRL_S_BIT])); // R6
    end
endmodule

// File: tb/eth_rx_pingpong_tb.sv
module eth_rx_pingpong_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic        pp_en = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_ready, frame_lost, irq;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [10:0] cpu_word = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int lost_cnt = 0;
    logic [7:0] frm [0:2099];

    localparam logic [10:0] B0 = 11'h400;
    localparam logic [10:0] B1 = 11'h600;
    localparam logic [10:0] C0 = 11'h5FF;
    localparam logic [10:0] C1 = 11'h7FF;
    localparam logic [10:0] GIE = 11'h1FE;

    always #10 clk = ~clk;

    eth_rx_pingpong dut_i (
        .clk(clk), .rst_n(rst_n), .station_addr(station_addr), .pp_en(pp_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_ready(rx_ready), .frame_lost(frame_lost), .irq(irq),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_word(cpu_word),
        .cpu_wdata(cpu_wdata), .rd_data(rd_data)
    );

    always @(negedge clk) begin
        if (rst_n && irq) irq_cnt++;
        if (rst_n && frame_lost) lost_cnt++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [31:0] v);
        @(negedge clk);
        cpu_word = a; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [31:0] v);
        @(negedge clk);
        cpu_word = a; cpu_rd = 1'b1;
        @(posedge clk);
        #1 v = rd_data;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic build(input logic [47:0] dest, input logic [7:0] seed);
        for (int i = 0; i < 2100; i++) frm[i] = 8'(seed + 8'(i * 3));
        for (int i = 0; i < 6; i++) frm[i] = dest[47-8*i -: 8];
    endtask

    task automatic send(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = frm[i];
            rx_sof = (i == 0); rx_eof = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_words(input string tag, input logic [10:0] base, input int len);
        int nw;
        logic [31:0] v, e;
        nw = (len + 3) / 4;
        if (nw > 511) nw = 511;
        for (int w = 0; w < nw; w++) begin
            for (int k = 0; k < 4; k++)
                e[31-8*k -: 8] = (4 * w + k < len) ? frm[4*w+k] : 8'h0;
            rd(base + 11'(w), v);
            chk($sformatf("%s word %0d", tag, w), v, e);
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 frame_lost", {31'b0, frame_lost}, 32'd0);
        rd(C0, v); chk("R1 ctrl0", v, 32'd0);
        rd(C1, v); chk("R1 ctrl1", v, 32'd0);
        rd(GIE, v); chk("R1 gie", v, 32'd0);
        rd(11'h000, v); chk("R2 unmapped read", v, 32'd0);
    endtask

    task automatic t_setup;
        logic [31:0] v;
        wr(GIE, 32'h8000_0000);
        wr(C0, 32'h8);
        wr(C1, 32'h8);
        rd(GIE, v); chk("R2 gie readback", v, 32'h8000_0000);
        rd(C0, v); chk("R10 ctrl0 I load", v, 32'h8);
    endtask

    task automatic t_unicast;
        int i0;
        logic [31:0] v;
        i0 = irq_cnt;
        build(48'h02_11_22_33_44_55, 8'h10);
        send(10);
        rd(C0, v); chk("R6 ctrl0 full", v, 32'h9);
        chk("R9 rx_ready low", {31'b0, rx_ready}, 32'd0);
        chk("R7 irq pulse", 32'(irq_cnt - i0), 32'd1);
        check_words("R3 R4 unicast buf0", B0, 10);
    endtask

    task automatic t_group;
        int i0;
        logic [31:0] v;
        i0 = irq_cnt;
        build(48'h81_00_00_00_00_07, 8'h40);
        send(7);
        rd(C1, v); chk("R8 ctrl1 full after toggle", v, 32'h9);
        chk("R7 irq pulse buf1", 32'(irq_cnt - i0), 32'd1);
        check_words("R4 R3 group buf1", B1, 7);
    endtask

    task automatic t_full_drop;
        int i0, l0;
        logic [31:0] w0, v;
        rd(B0, w0);
        i0 = irq_cnt; l0 = lost_cnt;
        build(48'hFF_FF_FF_FF_FF_FF, 8'h77);
        send(9);
        chk("R5 lost pulse", 32'(lost_cnt - l0), 32'd1);
        chk("R5 no irq", 32'(irq_cnt - i0), 32'd0);
        rd(B0, v); chk("R5 buf0 untouched", v, w0);
        rd(C0, v); chk("R5 ctrl0 unchanged", v, 32'h9);
    endtask

    task automatic t_mismatch;
        int i0, l0;
        logic [31:0] w0, v;
        wr(C0, 32'h8);
        chk("R10 R9 release rx_ready", {31'b0, rx_ready}, 32'd1);
        rd(B0, w0);
        i0 = irq_cnt; l0 = lost_cnt;
        build(48'h02_11_22_33_44_56, 8'h90);
        send(12);
        chk("R4 mismatch no irq", 32'(irq_cnt - i0), 32'd0);
        chk("R4 mismatch no lost", 32'(lost_cnt - l0), 32'd0);
        rd(C0, v); chk("R4 mismatch ctrl0", v, 32'h8);
        rd(B0, v); chk("R4 mismatch no write", v, w0);
        build(48'hFF_FF_FF_FF_FF_FF, 8'h33);
        send(4);
        rd(C0, v); chk("R4 short frame ignored", v, 32'h8);
        rd(B0, v); chk("R4 short frame no write", v, w0);
        wr(B0, 32'hDEAD_BEEF);
        rd(B0, v); chk("R10 data write ignored", v, w0);
    endtask

    task automatic t_no_gie;
        int i0;
        logic [31:0] v;
        wr(C1, 32'h8);
        wr(GIE, 32'h0);
        i0 = irq_cnt;
        build(48'h02_11_22_33_44_55, 8'hA0);
        send(6);
        rd(C0, v); chk("R6 six-byte frame full", v, 32'h9);
        chk("R7 no irq with gie off", 32'(irq_cnt - i0), 32'd0);
        check_words("R3 six-byte frame", B0, 6);
    endtask

    task automatic t_pp_off;
        int i0, l0;
        logic [31:0] v;
        wr(C0, 32'h8);
        wr(GIE, 32'h8000_0000);
        @(negedge clk) pp_en = 1'b0;
        i0 = irq_cnt; l0 = lost_cnt;
        build(48'h80_00_00_00_00_01, 8'h05);
        send(8);
        rd(C1, v); chk("R8 pp off first frame buf1", v, 32'h9);
        build(48'h80_00_00_00_00_02, 8'h06);
        send(8);
        chk("R8 pp off no toggle lost", 32'(lost_cnt - l0), 32'd1);
        chk("R7 pp off irq count", 32'(irq_cnt - i0), 32'd1);
        rd(C0, v); chk("R8 buf0 still free", v, 32'h8);
        chk("R9 rx_ready high", {31'b0, rx_ready}, 32'd1);
    endtask

    task automatic t_truncate;
        int i0;
        logic [31:0] v;
        @(negedge clk) pp_en = 1'b1;
        wr(C1, 32'h8);
        i0 = irq_cnt;
        build(48'hC0_00_00_00_00_00, 8'h21);
        send(2050);
        rd(C1, v); chk("R11 ctrl1 intact and full", v, 32'h9);
        chk("R11 irq on truncated frame", 32'(irq_cnt - i0), 32'd1);
        check_words("R11 truncated data", B1, 2050);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_unicast();
        t_group();
        t_full_drop();
        t_mismatch();
        t_no_gie();
        t_pp_off();
        t_truncate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule